// File: doc/BRIEF.md
# Selectable-Sense Character Parity Unit

This block protects characters crossing a byte-wide link with a single redundant bit. On its transmit side it accepts a 7-bit character and returns an 8-bit code byte. The character sits in the low seven bits and the computed parity bit sits in the most significant bit. On its receive side it accepts an 8-bit byte taken off the link and reports whether that byte breaks the parity rule.

One sense input chooses the rule for both sides at once. Low means even parity: the code byte holds an even number of ones. High means odd parity: it holds an odd number of ones. The sense value is sampled with each word, so it travels with that word.

Both paths share a single input strobe. A word presented with the strobe high is processed, and its results appear on the registered outputs on the next clock, together with an output strobe. Between words the outputs hold their last values. A synchronous active-high reset clears the outputs.

Top module: `parity_link_unit`

## Requirements
- R1: While reset is high at a clock edge, the following cycle shows `res_vld` = 0, `chk_err` = 0 and `enc_byte` = 0.
- R2: `res_vld` is 1 exactly in the cycle after a clock edge at which `req_vld` was 1, and 0 after an edge at which `req_vld` was 0.
- R3: After an accepted word, `enc_byte[6:0]` equals the `enc_char` value presented with that word.
- R4: With `odd_sense` = 0 captured, the accepted `enc_byte` holds an even number of ones in its 8 bits.
- R5: With `odd_sense` = 1 captured, the accepted `enc_byte` holds an odd number of ones in its 8 bits.
- R6: With `odd_sense` = 0 captured, `chk_err` is 1 exactly when `chk_byte` holds an odd number of ones.
- R7: With `odd_sense` = 1 captured, `chk_err` is 1 exactly when `chk_byte` holds an even number of ones.
- R8: A code byte produced by the encoder, fed back to the checker under the same sense with 1, 3, 5 or 7 bits inverted, gives `chk_err` = 1. With 0, 2, 4, 6 or 8 bits inverted, it gives `chk_err` = 0.
- R9: Inverting only bit 7, the parity bit, of an encoded byte gives `chk_err` = 1 under either sense.
- R10: The sense applied to a word is the `odd_sense` value sampled with that word. When `req_vld` is 0, changes on `odd_sense`, `enc_char` or `chk_byte` leave `enc_byte` and `chk_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_vld | input | 1 | Input word strobe |
| odd_sense | input | 1 | 0 selects even parity, 1 selects odd parity, for this word |
| enc_char | input | MSG_W | Character to encode |
| chk_byte | input | MSG_W+1 | Received byte to check |
| res_vld | output | 1 | Result strobe, one cycle after `req_vld` |
| enc_byte | output | MSG_W+1 | Parity bit at the top, character below |
| chk_err | output | 1 | Parity violation flag for `chk_byte` |

## Verification
The assertions assume that the strobe, the sense and both data inputs hold known values at every sampled edge, and that reset is applied before the first word. The bench meets both conditions. It drives every input on the falling edge from the first cycle, and it holds reset through several edges before any word is sent. The bench also exercises the idle case. It changes every data input while the strobe is low, which checks that the captured result and its sense persist.

// File: rtl/parity_pkg.sv
package parity_pkg;

    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } sense_e;

    // Fold a raw XOR reduction into the selected rule.
    function automatic logic sense_adjust(input logic raw, input sense_e s);
        return raw ^ (s == SENSE_ODD);
    endfunction

endpackage

// File: rtl/parity_encoder.sv
module parity_encoder
    import parity_pkg::*;
#(
    parameter int MSG_W = 7
) (
    input  logic [MSG_W-1:0] msg,
    input  sense_e           sense,
    output logic [MSG_W:0]   code
);
    logic pbit;

    always_comb begin
        pbit = sense_adjust(^msg, sense);
        code = {pbit, msg};
    end
endmodule

// File: rtl/parity_checker.sv
module parity_checker
    import parity_pkg::*;
#(
    parameter int MSG_W = 7
) (
    input  logic [MSG_W:0] word,
    input  sense_e         sense,
    output logic           bad
);
    always_comb begin
        bad = sense_adjust(^word, sense);
    end
endmodule

// File: rtl/parity_link_unit.sv
module parity_link_unit
    import parity_pkg::*;
#(
    parameter int MSG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_vld,
    input  logic             odd_sense,
    input  logic [MSG_W-1:0] enc_char,
    input  logic [MSG_W:0]   chk_byte,
    output logic             res_vld,
    output logic [MSG_W:0]   enc_byte,
    output logic             chk_err
);
    localparam int CODE_W = MSG_W + 1;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
        logic              err;
    } result_t;

    sense_e            sense_now;
    logic [CODE_W-1:0] code_nxt;
    logic              err_nxt;
    result_t           res_q;

    assign sense_now = odd_sense ? SENSE_ODD : SENSE_EVEN;

    parity_encoder #(.MSG_W(MSG_W)) u_enc (
        .msg   (enc_char),
        .sense (sense_now),
        .code  (code_nxt)
    );

    parity_checker #(.MSG_W(MSG_W)) u_chk (
        .word  (chk_byte),
        .sense (sense_now),
        .bad   (err_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld <= req_vld;
            if (req_vld) begin
                res_q.code <= code_nxt;
                res_q.err  <= err_nxt;
            end
        end
    end

    assign res_vld  = res_q.vld;
    assign enc_byte = res_q.code;
    assign chk_err  = res_q.err;
endmodule

// File: rtl/parity_link_unit_chk.sv
module parity_link_unit_chk #(
    parameter int MSG_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             req_vld,
    input logic             odd_sense,
    input logic [MSG_W-1:0] enc_char,
    input logic [MSG_W:0]   chk_byte,
    input logic             res_vld,
    input logic [MSG_W:0]   enc_byte,
    input logic             chk_err
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!res_vld && !chk_err && enc_byte == '0));

    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> res_vld);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !res_vld);

    a_r3_char_passes: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> enc_byte[MSG_W-1:0] == $past(enc_char));

    a_r4_r5_code_sense: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> ((^enc_byte) == $past(odd_sense)));

    a_r6_r7_check_sense: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> (chk_err == ((^$past(chk_byte)) != $past(odd_sense))));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!req_vld && !$past(rst)) |=> ($stable(enc_byte) && $stable(chk_err)));
endmodule

bind parity_link_unit parity_link_unit_chk #(.MSG_W(MSG_W)) u_bound_chk (
    .clk       (clk),
    .rst       (rst),
    .req_vld   (req_vld),
    .odd_sense (odd_sense),
    .enc_char  (enc_char),
    .chk_byte  (chk_byte),
    .res_vld   (res_vld),
    .enc_byte  (enc_byte),
    .chk_err   (chk_err)
);

// File: tb/sim_parity_link_unit.sv
`timescale 1ns/1ps
module sim_parity_link_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_vld = 1'b0;
    logic       odd_sense = 1'b0;
    logic [6:0] enc_char = '0;
    logic [7:0] chk_byte = '0;
    logic       res_vld;
    logic [7:0] enc_byte;
    logic       chk_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    parity_link_unit #(.MSG_W(7)) u0 (
        .clk(clk), .rst(rst), .req_vld(req_vld), .odd_sense(odd_sense),
        .enc_char(enc_char), .chk_byte(chk_byte),
        .res_vld(res_vld), .enc_byte(enc_byte), .chk_err(chk_err)
    );

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one word at a falling edge; results are sampled at the next falling edge.
    task automatic send(input logic v, input logic s, input logic [6:0] c, input logic [7:0] b);
        @(negedge clk);
        req_vld = v; odd_sense = s; enc_char = c; chk_byte = b;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] held_code;
        logic       held_err;
        repeat (3) @(negedge clk);
        check("R1 res_vld", res_vld, 0);
        check("R1 chk_err", chk_err, 0);
        check("R1 enc_byte", enc_byte, 0);
        rst = 1'b0;

        // Exhaustive sweep of both paths under both senses
        for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < 256; b++) begin
                send(1'b1, s[0], b[6:0], b[7:0]);
                check("R2 strobe", res_vld, 1);
                check("R3 char", enc_byte[6:0], b[6:0]);
                if (s == 0) check("R4 even count", ones(enc_byte) % 2, 0);
                else        check("R5 odd count", ones(enc_byte) % 2, 1);
                if (s == 0) check("R6 even check", chk_err, (ones(b[7:0]) % 2) == 1);
                else        check("R7 odd check", chk_err, (ones(b[7:0]) % 2) == 0);
            end
        end

        // Loopback with every flip mask
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 4; k++) begin
                logic [6:0] ch;
                logic [7:0] code;
                ch = (k == 0) ? 7'h00 : (k == 1) ? 7'h55 : (k == 2) ? 7'h7F : 7'h2A;
                send(1'b1, s[0], ch, 8'h00);
                code = enc_byte;
                for (int m = 0; m < 256; m++) begin
                    send(1'b1, s[0], ch, code ^ m[7:0]);
                    if (m == 8'h80) check("R9 parity bit flip", chk_err, 1);
                    else check("R8 flip count", chk_err, (ones(m[7:0]) % 2) == 1);
                end
            end
        end

        // Per-word sense and idle hold
        send(1'b1, 1'b1, 7'h01, 8'h01);
        check("R10 sense odd word", enc_byte, 8'h01);
        check("R10 sense odd err", chk_err, 0);
        send(1'b1, 1'b0, 7'h01, 8'h01);
        check("R10 sense even word", enc_byte, 8'h81);
        check("R10 sense even err", chk_err, 1);
        held_code = enc_byte;
        held_err  = chk_err;
        send(1'b0, 1'b1, 7'h3C, 8'hFF);
        check("R2 idle strobe", res_vld, 0);
        check("R10 idle code hold", enc_byte, held_code);
        check("R10 idle err hold", chk_err, held_err);
        send(1'b0, 1'b0, 7'h7E, 8'h00);
        check("R10 idle code hold 2", enc_byte, held_code);
        check("R10 idle err hold 2", chk_err, held_err);

        // Reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset vld", res_vld, 0);
        check("R1 mid reset err", chk_err, 0);
        check("R1 mid reset code", enc_byte, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule